// File: doc/BRIEF.md
# Multiframe Clock and Lane Alignment Start Controller

This block belongs to the transmit side of a JESD204B-style converter link and runs in the frame-clock domain. It keeps a local multiframe counter that is `K_FRAMES` frames long and emits a boundary strobe once per multiframe. Each rising edge of the sampled SYSREF input moves the counter's phase, so a boundary follows directly after that edge.

SYSREF pulses are counted, and the count saturates. The first pulses are passed on as reset strobes for the clock divider and for the NCO phase. Once enough pulses have arrived, a divider mask and then an NCO mask are raised. From that point later pulses leave those subsystems alone, while the multiframe counter still follows every edge.

The active-low SYNC request holds the link in code-group synchronization while it is low. When SYNC is released, the link arms and starts initial lane alignment only at the next multiframe boundary. It then stays in the data state until SYNC is requested again. A SYSREF edge that arrives during data and is not in phase with the running multiframe is flagged as a link disruption.

Top module: `jesd_mf_ila_ctrl`

## Requirements
- R1: While `rst_ni` is low, the following hold: the multiframe counter is zero (`mf_bound_o` = 1), `link_state_o` = 0, both masks are 0, the pulse count is zero, and `ila_start_o`, `div_rst_o`, `nco_rst_o` and `disrupt_o` are 0.
- R2: Between realignments, `mf_bound_o` is high for one cycle in every `K_FRAMES` cycles (default 32). After reset release the first strobe is in the first cycle.
- R3: `sysref_i` and `sync_ni` each pass through a two-flop synchronizer. If `sysref_i` goes from 0 to 1 before clock edge n, then the edge is detected between edges n+1 and n+2, and `mf_bound_o` is high between edges n+2 and n+3. The strobe then repeats every `K_FRAMES` cycles.
- R4: Holding `sysref_i` high has the effect of a single edge only. There is no further realignment and no further divider or NCO reset strobe.
- R5: `div_rst_o` pulses in the edge-detect cycle of SYSREF edges 1 and 2 after reset. `div_mask_o` rises after edge 2, and from then on no edge produces `div_rst_o`.
- R6: `nco_rst_o` pulses on SYSREF edges 1 to 3. `nco_mask_o` rises after edge 3, and from then on no edge produces `nco_rst_o`.
- R7: The pulse count saturates, so both masks stay high through any number of further edges until reset.
- R8: `link_state_o` encodes 0 = sync, 1 = armed, 2 = data. The sync state is entered on the third clock edge after `sync_ni` is sampled low. The armed state is entered on the third clock edge after `sync_ni` is sampled high while in sync.
- R9: In the armed state, `ila_start_o` is raised at the first multiframe boundary, and the state becomes data.
- R10: If the synchronized SYNC release coincides with a boundary cycle, that boundary is missed and `ila_start_o` comes `K_FRAMES` cycles later.
- R11: The data state holds until SYNC is requested again. No further `ila_start_o` occurs in it.
- R12: In the data state, a SYSREF edge detected while the counter is not at its last count (`K_FRAMES`-1) raises `disrupt_o` for that cycle. An edge detected at the last count leaves the boundary phase unchanged and raises no flag.
- R13: `ila_start_o` is a single-cycle pulse and always coincides with `mf_bound_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | frame clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sysref_i | input | 1 | SYSREF timing reference |
| sync_ni | input | 1 | SYNC request, active low |
| mf_bound_o | output | 1 | multiframe boundary strobe |
| ila_start_o | output | 1 | lane alignment start pulse |
| link_state_o | output | 2 | 0 sync, 1 armed, 2 data |
| div_rst_o | output | 1 | clock-divider phase reset strobe |
| nco_rst_o | output | 1 | NCO phase reset strobe |
| div_mask_o | output | 1 | divider reset masked |
| nco_mask_o | output | 1 | NCO reset masked |
| disrupt_o | output | 1 | out-of-phase SYSREF during data |

## Verification
The bench releases SYNC at a mid-multiframe phase and also in exactly the boundary cycle. A design that arms combinationally would start one multiframe early in the second case, and one that ignores the boundary would start at once in the first. SYSREF is held high for two multiframes, so a level-sensitive realignment shows up as a shifted or missing strobe. Five pulses in a row expose masks that rise on the wrong count or a pulse count that wraps and drops them. Edges in phase and out of phase during data separate a correct disruption flag from one that fires on every edge.

// File: rtl/jesd_mfc_pkg.sv
package jesd_mfc_pkg;
  typedef enum logic [1:0] {
    LINK_CGS   = 2'd0,
    LINK_ARMED = 2'd1,
    LINK_DATA  = 2'd2
  } link_state_e;
endpackage

// File: rtl/mfc_sync2.sv
module mfc_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mfc_mf_counter.sv
module mfc_mf_counter #(
  parameter int K_FRAMES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic realign_i,
  output logic mf_bound_o,
  output logic mf_last_o
);
  localparam int CNT_W = (K_FRAMES > 1) ? $clog2(K_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(K_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (realign_i)   cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign mf_bound_o = (cnt_q == '0);
  assign mf_last_o  = (cnt_q == LAST);

  // R2
  bound_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mf_bound_o && !realign_i) |=> !mf_bound_o);
  // R3
  realign_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> mf_bound_o);
endmodule

// File: rtl/mfc_sysref_ctrl.sv
module mfc_sysref_ctrl #(
  parameter int PCNT_W    = 2,
  parameter int DIV_AFTER = 2,
  parameter int NCO_AFTER = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_s_i,
  output logic rise_o,
  output logic div_rst_o,
  output logic nco_rst_o,
  output logic div_mask_o,
  output logic nco_mask_o
);
  localparam logic [PCNT_W-1:0] DIV_THR = PCNT_W'(DIV_AFTER);
  localparam logic [PCNT_W-1:0] NCO_THR = PCNT_W'(NCO_AFTER);
  localparam logic [PCNT_W-1:0] PMAX    = '1;

  logic              sr_d_q;
  logic [PCNT_W-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_d_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      sr_d_q <= sr_s_i;
      // saturate so masks never drop
      if (rise_o && pcnt_q != PMAX) pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign rise_o     = sr_s_i & ~sr_d_q;
  assign div_mask_o = (pcnt_q >= DIV_THR);
  assign nco_mask_o = (pcnt_q >= NCO_THR);
  assign div_rst_o  = rise_o & ~div_mask_o;
  assign nco_rst_o  = rise_o & ~nco_mask_o;

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R7
  div_mask_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_mask_o |=> div_mask_o);
  // R7
  nco_mask_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nco_mask_o |=> nco_mask_o);
endmodule

// File: rtl/mfc_link_fsm.sv
module mfc_link_fsm
  import jesd_mfc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_s_ni,
  input  logic       mf_bound_i,
  input  logic       mf_last_i,
  input  logic       sr_rise_i,
  output logic [1:0] state_o,
  output logic       ila_start_o,
  output logic       disrupt_o
);
  link_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!sync_s_ni) st_d = LINK_CGS;
    else begin
      unique case (st_q)
        LINK_CGS:   st_d = LINK_ARMED;
        LINK_ARMED: if (mf_bound_i) st_d = LINK_DATA;
        LINK_DATA:  st_d = LINK_DATA;
        default:    st_d = LINK_CGS;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LINK_CGS;
    else         st_q <= st_d;
  end

  assign state_o     = st_q;
  assign ila_start_o = (st_q == LINK_ARMED) & mf_bound_i & sync_s_ni;
  // in phase means the edge lands where the counter would wrap anyway
  assign disrupt_o   = (st_q == LINK_DATA) & sr_rise_i & ~mf_last_i;

  // R8
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_s_ni |=> (state_o == LINK_CGS));
  // R13
  ila_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ila_start_o |=> (!ila_start_o && state_o == LINK_DATA));
endmodule

// File: rtl/jesd_mf_ila_ctrl.sv
module jesd_mf_ila_ctrl #(
  parameter int K_FRAMES  = 32,
  parameter int PCNT_W    = 2,
  parameter int DIV_AFTER = 2,
  parameter int NCO_AFTER = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sysref_i,
  input  logic       sync_ni,
  output logic       mf_bound_o,
  output logic       ila_start_o,
  output logic [1:0] link_state_o,
  output logic       div_rst_o,
  output logic       nco_rst_o,
  output logic       div_mask_o,
  output logic       nco_mask_o,
  output logic       disrupt_o
);
  logic [1:0] sync_q;
  logic       sr_rise, mf_last;

  mfc_sync2 #(.W(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sync_ni, sysref_i}),
    .q_o   (sync_q)
  );

  mfc_sysref_ctrl #(
    .PCNT_W   (PCNT_W),
    .DIV_AFTER(DIV_AFTER),
    .NCO_AFTER(NCO_AFTER)
  ) i_sysref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sr_s_i    (sync_q[0]),
    .rise_o    (sr_rise),
    .div_rst_o (div_rst_o),
    .nco_rst_o (nco_rst_o),
    .div_mask_o(div_mask_o),
    .nco_mask_o(nco_mask_o)
  );

  mfc_mf_counter #(.K_FRAMES(K_FRAMES)) i_mf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .realign_i (sr_rise),
    .mf_bound_o(mf_bound_o),
    .mf_last_o (mf_last)
  );

  mfc_link_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_s_ni  (sync_q[1]),
    .mf_bound_i (mf_bound_o),
    .mf_last_i  (mf_last),
    .sr_rise_i  (sr_rise),
    .state_o    (link_state_o),
    .ila_start_o(ila_start_o),
    .disrupt_o  (disrupt_o)
  );

  // R12
  disrupt_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disrupt_o |=> mf_bound_o);
  // R13
  ila_on_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ila_start_o |-> (mf_bound_o && link_state_o == 2'd1));
endmodule

// File: tb/test_jesd_mf_ila_ctrl.sv
module test_jesd_mf_ila_ctrl;
  localparam int K = 32;

  logic clk = 1'b0;
  logic rst_ni, sysref_i, sync_ni;
  logic mf_bound_o, ila_start_o, div_rst_o, nco_rst_o;
  logic div_mask_o, nco_mask_o, disrupt_o;
  logic [1:0] link_state_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int b0 = 0;

  always #4 clk = ~clk;

  jesd_mf_ila_ctrl #(.K_FRAMES(K)) i_jesd_mf_ila_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sysref_i(sysref_i), .sync_ni(sync_ni),
    .mf_bound_o(mf_bound_o), .ila_start_o(ila_start_o),
    .link_state_o(link_state_o), .div_rst_o(div_rst_o),
    .nco_rst_o(nco_rst_o), .div_mask_o(div_mask_o),
    .nco_mask_o(nco_mask_o), .disrupt_o(disrupt_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; cyc++;
  endtask

  function automatic int phase();
    return (cyc - b0) % K;
  endfunction

  task automatic step_bound(input string req);
    step();
    chk(req, "mf_bound_o", int'(mf_bound_o), int'(phase() == 0));
  endtask

  task automatic wait_phase(input int ph);
    while (phase() != ph) step_bound("R2");
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; sysref_i = 1'b0; sync_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mf_bound_o", int'(mf_bound_o), 1);
    chk("R1", "link_state_o", int'(link_state_o), 0);
    chk("R1", "masks", int'({div_mask_o, nco_mask_o}), 0);
    chk("R1", "ila/div/nco/disrupt", int'({ila_start_o, div_rst_o, nco_rst_o, disrupt_o}), 0);
    rst_ni = 1'b1;
    cyc = 0; b0 = 0;
  endtask

  task automatic t_period();
    for (int i = 0; i < 3 * K; i++) step_bound("R2");
  endtask

  // one SYSREF pulse, high for hi cycles, with expected strobes and masks
  task automatic sr_pulse(input int hi, input int e_div, input int e_nco,
                          input int e_dm, input int e_nm, input string req);
    sysref_i = 1'b1;
    step();
    step();
    chk(req, "div_rst_o", int'(div_rst_o), e_div);
    chk(req, "nco_rst_o", int'(nco_rst_o), e_nco);
    chk("R12", "disrupt_o in sync state", int'(disrupt_o), 0);
    step();
    b0 = cyc;
    chk("R3", "mf_bound_o after edge", int'(mf_bound_o), 1);
    chk(req, "div_mask_o", int'(div_mask_o), e_dm);
    chk(req, "nco_mask_o", int'(nco_mask_o), e_nm);
    for (int i = 3; i < hi; i++) begin
      step_bound("R4");
      chk("R4", "strobes under held level", int'({div_rst_o, nco_rst_o}), 0);
    end
    sysref_i = 1'b0;
    for (int i = 0; i < 5; i++) step_bound("R3");
    chk("R7", "div_mask_o kept", int'(div_mask_o), e_dm);
    chk("R7", "nco_mask_o kept", int'(nco_mask_o), e_nm);
  endtask

  task automatic t_masks();
    wait_phase(7);
    sr_pulse(2 * K, 1, 1, 0, 0, "R4");
    wait_phase(11);
    sr_pulse(3, 1, 1, 1, 0, "R5");
    wait_phase(20);
    sr_pulse(3, 0, 1, 1, 1, "R6");
    sr_pulse(3, 0, 0, 1, 1, "R7");
    sr_pulse(4, 0, 0, 1, 1, "R7");
    t_period();
  endtask

  task automatic t_ila_normal();
    int rel, exp_t;
    wait_phase(5);
    sync_ni = 1'b1;
    rel = cyc;
    exp_t = rel + (K - 5);
    while (cyc < exp_t - 1) begin
      step_bound("R9");
      chk("R9", "ila_start_o early", int'(ila_start_o), 0);
      if (cyc == rel + 2) chk("R8", "still sync", int'(link_state_o), 0);
      if (cyc == rel + 3) chk("R8", "armed", int'(link_state_o), 1);
    end
    step();
    chk("R9", "ila_start_o at boundary", int'(ila_start_o), 1);
    chk("R13", "ila with boundary", int'(mf_bound_o), 1);
    step();
    chk("R13", "ila_start_o single", int'(ila_start_o), 0);
    chk("R9", "data state", int'(link_state_o), 2);
    for (int i = 0; i < 2 * K; i++) begin
      step_bound("R11");
      chk("R11", "stay data", int'(link_state_o), 2);
      chk("R11", "no ila in data", int'(ila_start_o), 0);
    end
  endtask

  task automatic t_resync();
    sync_ni = 1'b0;
    step(); step();
    chk("R11", "data until sync seen", int'(link_state_o), 2);
    step();
    chk("R8", "back to sync", int'(link_state_o), 0);
    for (int i = 0; i < K + 3; i++) begin
      step_bound("R8");
      chk("R8", "hold sync", int'(link_state_o), 0);
      chk("R8", "no ila in sync", int'(ila_start_o), 0);
    end
  endtask

  task automatic t_ila_late();
    int rel;
    wait_phase(K - 2);
    sync_ni = 1'b1;
    rel = cyc;
    step_bound("R10");
    step_bound("R10");
    chk("R10", "no ila on coincident boundary", int'(ila_start_o), 0);
    while (cyc < rel + 2 + K - 1) begin
      step_bound("R10");
      chk("R10", "ila_start_o early", int'(ila_start_o), 0);
    end
    step();
    chk("R10", "ila_start_o one multiframe later", int'(ila_start_o), 1);
    step();
    chk("R10", "data state", int'(link_state_o), 2);
  endtask

  task automatic t_disrupt();
    wait_phase(K - 3);
    sysref_i = 1'b1;
    step(); step();
    chk("R12", "aligned edge no flag", int'(disrupt_o), 0);
    step_bound("R12");
    sysref_i = 1'b0;
    for (int i = 0; i < K; i++) step_bound("R12");
    wait_phase(10);
    sysref_i = 1'b1;
    step(); step();
    chk("R12", "misaligned edge flag", int'(disrupt_o), 1);
    step();
    b0 = cyc;
    chk("R12", "realigned boundary", int'(mf_bound_o), 1);
    chk("R12", "flag single cycle", int'(disrupt_o), 0);
    sysref_i = 1'b0;
    for (int i = 0; i < 2 * K; i++) begin
      step_bound("R12");
      chk("R12", "no flag", int'(disrupt_o), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_masks();
    t_ila_normal();
    t_resync();
    t_ila_late();
    t_disrupt();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule